// File: doc/BRIEF.md
# Prioritized Interrupt Selector

This block decides which pending interrupt a hart should take in the current cycle. It looks at the pending vector, the delegation mask, the hart's current privilege level, the two global enable bits for machine and supervisor level, and a flag that is high while the hart is in debug mode. Its result is registered: one cycle after the inputs are presented, it shows a take strobe and a trap cause word.

The selection works in stages. First it forms the machine-level candidate set: the pending bits that are not delegated, gated by the machine enable rule. If that set is empty, it forms the supervisor-level set: the delegated pending bits, gated by the supervisor enable rule. Next a fixed class ordering narrows the chosen set to one class. Last, the lowest set bit of what remains gives the interrupt number. The trap entry logic that updates status and the program counter sits downstream and uses the registered strobe and cause.

Top module: `irq_prio_select`

## Requirements
- R1: Privilege is encoded U=2'b00, S=2'b01, M=2'b11. A non-delegated pending bit (delegation bit 0) is a machine candidate only when the privilege is U or S, or when the privilege is M and the machine enable input is 1.
- R2: Delegated pending bits (delegation bit 1) are considered only when the machine candidate set is empty. A machine candidate therefore wins over any supervisor candidate, whatever the class of either.
- R3: A delegated pending bit is a supervisor candidate only when the privilege is U, or when the privilege is S and the supervisor enable input is 1. At privilege M it is never taken.
- R4: While the debug-active input is 1, no interrupt is taken.
- R5: If the chosen set has any bit at a position of 12 or higher (above the machine external interrupt at bit 11), every bit below 12 is discarded.
- R6: Otherwise the class order is external (bits 11, 9), then software (bits 3, 1), then timer (bits 7, 5). Only the highest nonempty class is kept.
- R7: If the chosen set holds none of the bits named in R5 and R6, the whole set is kept.
- R8: The interrupt number is the position of the lowest set bit of the kept set.
- R9: When an interrupt is taken, the cause output has bit XLEN-1 set and the interrupt number in its low bits, with zeros in between. When none is taken, the cause output is all zero.
- R10: If the chosen set is empty, take is 0. The outputs reflect the inputs sampled at the previous rising clock edge.
- R11: While reset is high and in the cycle after it, take and cause read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NIRQ | Pending interrupt bits |
| deleg_i | input | NIRQ | Delegation mask, 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege (U=00, S=01, M=11) |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| dbg_active_i | input | 1 | Hart is in debug mode |
| take_o | output | 1 | Take-interrupt strobe, registered |
| cause_o | output | XLEN | Trap cause: interrupt flag plus interrupt number |

## Verification
The bench builds the block with NIRQ = 16 and XLEN = 64. With NIRQ = 16, bits 12 to 15 exist as custom lines, so the custom-over-standard rule of R5 can be exercised. With XLEN = 64, the interrupt flag lands in bit 63 and a 4-bit number sits in the low bits, so any stray bit in the gap between them is visible. Directed cases pit machine against supervisor candidates across all three privilege levels, and randomized cases cover mixed delegation masks.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    // Standard interrupt line positions used by the class ordering
    localparam int IRQ_SSW  = 1;
    localparam int IRQ_MSW  = 3;
    localparam int IRQ_STMR = 5;
    localparam int IRQ_MTMR = 7;
    localparam int IRQ_SEXT = 9;
    localparam int IRQ_MEXT = 11;

    localparam int IDX_W_MAX = 8;

    typedef struct packed {
        logic                 take;
        logic [IDX_W_MAX-1:0] num;
    } irq_pick_t;

endpackage

// File: rtl/irq_cand_filter.sv
module irq_cand_filter
    import irq_sel_pkg::*;
#(
    parameter int NIRQ = 16
) (
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] deleg,
    input  logic [1:0]      priv,
    input  logic            mie,
    input  logic            sie,
    output logic [NIRQ-1:0] cand
);
    logic            m_en;
    logic            s_en;
    logic [NIRQ-1:0] m_set;
    logic [NIRQ-1:0] s_set;

    always_comb begin
        m_en  = (priv != PRIV_M) || mie;
        s_en  = (priv == PRIV_U) || ((priv == PRIV_S) && sie);
        m_set = pend & ~deleg & {NIRQ{m_en}};
        s_set = pend &  deleg & {NIRQ{s_en}};
        cand  = (|m_set) ? m_set : s_set;
    end
endmodule

// File: rtl/irq_class_gate.sv
module irq_class_gate
    import irq_sel_pkg::*;
#(
    parameter int NIRQ = 16
) (
    input  logic [NIRQ-1:0] cand,
    output logic [NIRQ-1:0] kept
);
    localparam logic [NIRQ-1:0] ONE   = NIRQ'(1);
    localparam logic [NIRQ-1:0] EXT_M = (ONE << IRQ_MEXT) | (ONE << IRQ_SEXT);
    localparam logic [NIRQ-1:0] SW_M  = (ONE << IRQ_MSW)  | (ONE << IRQ_SSW);
    localparam logic [NIRQ-1:0] TMR_M = (ONE << IRQ_MTMR) | (ONE << IRQ_STMR);

    logic [NIRQ-1:0] cust_m;

    generate
        if (NIRQ > IRQ_MEXT + 1) begin : g_cust
            assign cust_m = ~((ONE << (IRQ_MEXT + 1)) - ONE);
        end else begin : g_nocust
            assign cust_m = '0;
        end
    endgenerate

    always_comb begin
        if (|(cand & cust_m))      kept = cand & cust_m;
        else if (|(cand & EXT_M))  kept = cand & EXT_M;
        else if (|(cand & SW_M))   kept = cand & SW_M;
        else if (|(cand & TMR_M))  kept = cand & TMR_M;
        else                       kept = cand;
    end
endmodule

// File: rtl/irq_lsb_index.sv
module irq_lsb_index #(
    parameter int NIRQ = 16,
    parameter int IDW  = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0] vec,
    output logic            found,
    output logic [IDW-1:0]  idx
);
    function automatic logic [NIRQ-1:0] pos_mask(input int b);
        logic [NIRQ-1:0] m;
        for (int i = 0; i < NIRQ; i++) m[i] = ((i >> b) & 1) == 1;
        return m;
    endfunction

    logic [NIRQ-1:0] lsb;
    assign lsb   = vec & (~vec + NIRQ'(1));
    assign found = |vec;

    generate
        for (genvar b = 0; b < IDW; b++) begin : g_bit
            localparam logic [NIRQ-1:0] SEL = pos_mask(b);
            assign idx[b] = |(lsb & SEL);
        end
    endgenerate
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_sel_pkg::*;
#(
    parameter int NIRQ = 16,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic            dbg_active_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [NIRQ-1:0] cand;
    logic [NIRQ-1:0] kept;
    logic            found;
    logic [IDW-1:0]  idx;
    irq_pick_t       pick_d;
    irq_pick_t       pick_q;

    irq_cand_filter #(.NIRQ(NIRQ)) u_filter (
        .pend (pend_i),
        .deleg(deleg_i),
        .priv (priv_i),
        .mie  (mie_i),
        .sie  (sie_i),
        .cand (cand)
    );

    irq_class_gate #(.NIRQ(NIRQ)) u_class (
        .cand(cand),
        .kept(kept)
    );

    irq_lsb_index #(.NIRQ(NIRQ), .IDW(IDW)) u_lsb (
        .vec  (kept),
        .found(found),
        .idx  (idx)
    );

    always_comb begin
        pick_d      = '0;
        pick_d.take = found && !dbg_active_i;
        if (pick_d.take) pick_d.num = IDX_W_MAX'(idx);
    end

    always_ff @(posedge clk) begin
        if (rst) pick_q <= '0;
        else     pick_q <= pick_d;
    end

    assign take_o  = pick_q.take;
    assign cause_o = pick_q.take ? {1'b1, (XLEN-1)'(pick_q.num)} : '0;
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk #(
    parameter int NIRQ = 16,
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [NIRQ-1:0] pend_i,
    input logic [NIRQ-1:0] deleg_i,
    input logic [1:0]      priv_i,
    input logic            mie_i,
    input logic            sie_i,
    input logic            dbg_active_i,
    input logic            take_o,
    input logic [XLEN-1:0] cause_o
);
    a_r4_debug_blocks: assert property (@(posedge clk) disable iff (rst)
        dbg_active_i |=> !take_o);

    a_r10_empty_no_take: assert property (@(posedge clk) disable iff (rst)
        (pend_i == '0) |=> !take_o);

    a_r9_cause_flag: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:0] < (XLEN-1)'(NIRQ))));

    a_r9_idle_cause_zero: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (cause_o == '0));

    a_r1_m_masked: assert property (@(posedge clk) disable iff (rst)
        (priv_i == 2'b11 && !mie_i && deleg_i == '1) |=> !take_o);

    a_r3_s_at_m_blocked: assert property (@(posedge clk) disable iff (rst)
        (priv_i == 2'b11 && deleg_i == '1) |=> !take_o);

    a_r5_custom_first: assert property (@(posedge clk) disable iff (rst)
        (!dbg_active_i && priv_i == 2'b00 && deleg_i == '0 && (|(pend_i >> 12)))
        |=> (take_o && cause_o[XLEN-2:0] >= (XLEN-1)'(12)));
endmodule

bind irq_prio_select irq_prio_select_chk #(.NIRQ(NIRQ), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pend_i      (pend_i),
    .deleg_i     (deleg_i),
    .priv_i      (priv_i),
    .mie_i       (mie_i),
    .sie_i       (sie_i),
    .dbg_active_i(dbg_active_i),
    .take_o      (take_o),
    .cause_o     (cause_o)
);

// File: tb/irq_prio_select_bench.sv
module irq_prio_select_bench;
    localparam int NIRQ = 16;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NIRQ-1:0] pend_i = '0;
    logic [NIRQ-1:0] deleg_i = '0;
    logic [1:0]      priv_i = 2'b11;
    logic            mie_i = 1'b0;
    logic            sie_i = 1'b0;
    logic            dbg_active_i = 1'b0;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_prio_select #(.NIRQ(NIRQ), .XLEN(XLEN)) u_irq_prio_select (
        .clk(clk), .rst(rst), .pend_i(pend_i), .deleg_i(deleg_i),
        .priv_i(priv_i), .mie_i(mie_i), .sie_i(sie_i),
        .dbg_active_i(dbg_active_i), .take_o(take_o), .cause_o(cause_o)
    );

    // Behavioural reference
    function automatic void ref_pick(input logic [15:0] p, input logic [15:0] d,
                                     input logic [1:0] pv, input bit m, input bit s,
                                     input bit dbg, output bit tk, output logic [63:0] cs);
        int set, keep, num;
        bit men, sen;
        tk = 0; cs = 0;
        if (dbg) return;
        men = (pv != 2'b11) || m;
        sen = (pv == 2'b00) || (pv == 2'b01 && s);
        set = men ? int'(p & ~d) : 0;
        if (set == 0) set = sen ? int'(p & d) : 0;
        if (set == 0) return;
        if ((set & 'hF000) != 0)      keep = set & 'hF000;
        else if ((set & 'hA00) != 0)  keep = set & 'hA00;
        else if ((set & 'h00A) != 0)  keep = set & 'h00A;
        else if ((set & 'h0A0) != 0)  keep = set & 'h0A0;
        else                          keep = set;
        num = 0;
        while (((keep >> num) & 1) == 0) num++;
        tk = 1;
        cs = (64'd1 << 63) | 64'(num);
    endfunction

    task automatic step(input logic [15:0] p, input logic [15:0] d, input logic [1:0] pv,
                        input bit m, input bit s, input bit dbg, input string tag);
        bit          etk;
        logic [63:0] ecs;
        @(negedge clk);
        pend_i = p; deleg_i = d; priv_i = pv; mie_i = m; sie_i = s; dbg_active_i = dbg;
        ref_pick(p, d, pv, m, s, dbg, etk, ecs);
        @(posedge clk);
        #2;
        n_run++;
        if (take_o !== etk || cause_o !== ecs) begin
            n_fail++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     tag, take_o, cause_o, etk, ecs);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R11: reset with live pending inputs
        pend_i = 16'h0888; priv_i = 2'b00;
        repeat (3) @(posedge clk);
        #2;
        n_run++;
        if (take_o !== 1'b0 || cause_o !== '0) begin
            n_fail++;
            $display("FAIL R11: take=%0b cause=%h expected take=0 cause=0", take_o, cause_o);
        end
        @(negedge clk); rst = 1'b0;

        // R1: machine enable rule
        step(16'h0008, 16'h0000, 2'b11, 0, 0, 0, "R1");
        step(16'h0008, 16'h0000, 2'b11, 1, 0, 0, "R1");
        step(16'h0008, 16'h0000, 2'b01, 0, 0, 0, "R1");
        step(16'h0008, 16'h0000, 2'b00, 0, 0, 0, "R1");
        // R3: supervisor enable rule
        step(16'h0002, 16'h0002, 2'b01, 1, 0, 0, "R3");
        step(16'h0002, 16'h0002, 2'b01, 0, 1, 0, "R3");
        step(16'h0002, 16'h0002, 2'b00, 0, 0, 0, "R3");
        step(16'h0002, 16'h0002, 2'b11, 1, 1, 0, "R3");
        // R2: machine candidate beats supervisor one of higher class
        step(16'h0280, 16'h0200, 2'b00, 0, 0, 0, "R2");
        step(16'h0280, 16'h0200, 2'b11, 0, 1, 0, "R2");
        // R4: debug
        step(16'h0800, 16'h0000, 2'b00, 1, 1, 1, "R4");
        // R5: custom lines
        step(16'h2800, 16'h0000, 2'b00, 0, 0, 0, "R5");
        step(16'hC00A, 16'h0000, 2'b00, 0, 0, 0, "R5");
        // R6: class order
        step(16'h0288, 16'h0000, 2'b00, 0, 0, 0, "R6");
        step(16'h0088, 16'h0000, 2'b00, 0, 0, 0, "R6");
        step(16'h00A0, 16'h0000, 2'b00, 0, 0, 0, "R6");
        step(16'h0A0A, 16'h0000, 2'b00, 0, 0, 0, "R6");
        // R7: unclassified bits only
        step(16'h0414, 16'h0000, 2'b00, 0, 0, 0, "R7");
        // R8: lowest bit within class
        step(16'h000A, 16'h0000, 2'b00, 0, 0, 0, "R8");
        step(16'h0A00, 16'h0000, 2'b00, 0, 0, 0, "R8");
        // R9: cause format, highest number
        step(16'h8000, 16'h0000, 2'b00, 0, 0, 0, "R9");
        // R10: empty set
        step(16'h0000, 16'hFFFF, 2'b00, 1, 1, 0, "R10");

        for (int k = 0; k < 400; k++) begin
            logic [1:0] pv;
            int r;
            r  = $urandom_range(0, 2);
            pv = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
            step(16'($urandom), 16'($urandom), pv, 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 7) == 0), "R8_random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule